// File: doc/BRIEF.md
# ALU Status Flag Register Unit

This block holds the eight-bit condition register of a small accumulator-style processor core. It watches the two ALU operands and an operation code. When flag updates are enabled it derives carry, nibble carry, zero, negative and signed-overflow flags for add, subtract, rotate-through-carry and bitwise operations. Subtraction is carried out as an add of the one's complement plus one, so the carry flag reads 1 when no borrow occurred. Software can overwrite the five arithmetic flags. Two further flags can be read but not written by software. They record watchdog time-out and power-down, and they move on clear-watchdog, sleep and time-out strobes.

A shadow copy of the register is taken on an interrupt-entry strobe. On the matching return strobe the arithmetic flags are written back from it. The two power-management flags always keep their live values. All outputs come from registers. The reset is an asynchronous, active-low power-on reset.

Top module: `status_flag_unit`

## Requirements
- R1: After power-on reset, `statusOut` is 0x60 (time-out flag and power-down flag set, all others clear) and `shadowOut` is 0x00.
- R2: Register layout: bit 0 carry, bit 1 nibble carry, bit 2 zero, bit 3 overflow, bit 4 negative, bit 5 power-down, bit 6 time-out, bit 7 always reads 0. Add (`aluOp`=0) sets carry to the carry out of bit 7. It sets nibble carry to the carry out of bit 3. Zero is set when the 8-bit sum is 0, and negative is sum bit 7.
- R3: Subtract (`aluOp`=1) computes A + ~B + 1. Carry and nibble carry are the carry-outs of that addition, so 1 means no borrow. Zero and negative follow the 8-bit difference.
- R4: For add and subtract, overflow is set exactly when the two's-complement result leaves the range -128..127.
- R5: Rotate right through carry (`aluOp`=2) gives {C, A[7:1]} and loads C from A[0]. Rotate left through carry (`aluOp`=3) gives {A[6:0], C} and loads C from A[7]. Zero and negative follow the rotated value. Nibble carry and overflow are unchanged.
- R6: AND (4), OR (5), XOR (6) and pass-A (7) update only zero and negative from the result. Carry, nibble carry and overflow are unchanged.
- R7: With `flagUpdEn`, `swWrEn` and `irqReturn` all low, bits 4:0 do not change.
- R8: `swWrEn` loads `swWrData[4:0]` into bits 4:0. Data bits 7:5 are ignored: the time-out and power-down flags keep their values and bit 7 stays 0.
- R9: `clrWdt` sets time-out and power-down. `sleepCmd` sets time-out and clears power-down. `wdtTimeout` clears time-out. Time-out wins over the other two on the time-out flag, and sleep wins over clear-watchdog on the power-down flag.
- R10: `irqEnter` loads `shadowOut` with the value `statusOut` held before that clock edge.
- R11: `irqReturn` loads bits 4:0 from `shadowOut[4:0]`. The time-out and power-down flags are never taken from the shadow.
- R12: For bits 4:0, `irqReturn` has priority over `swWrEn`, and `swWrEn` has priority over `flagUpdEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| aluOpA | input | 8 | First ALU operand |
| aluOpB | input | 8 | Second ALU operand |
| aluOp | input | 3 | Operation code (see R2, R3, R5, R6) |
| flagUpdEn | input | 1 | Update flags from the current operation |
| swWrEn | input | 1 | Software write of the arithmetic flags |
| swWrData | input | 8 | Software write data |
| clrWdt | input | 1 | Clear-watchdog strobe |
| sleepCmd | input | 1 | Sleep strobe |
| wdtTimeout | input | 1 | Watchdog time-out strobe |
| irqEnter | input | 1 | Interrupt entry: capture shadow |
| irqReturn | input | 1 | Interrupt return: restore from shadow |
| statusOut | output | 8 | Status register |
| shadowOut | output | 8 | Shadow copy |

## Verification
Every result is due exactly one rising edge after its stimulus. Flag updates, software writes, power-management events, the shadow capture and the restore all land in the status or shadow register on the first edge that sees the strobe. The bench drives inputs on the falling edge, lets one rising edge pass and reads the outputs on the next falling edge. Strobes are dropped before the following rising edge. Each expected value therefore reflects exactly one update. Operations whose flags must not move are followed by a read in that same slot, before any further stimulus.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_RRC  = 3'd2,
    OP_RLC  = 3'd3,
    OP_AND  = 3'd4,
    OP_IOR  = 3'd5,
    OP_XOR  = 3'd6,
    OP_PASS = 3'd7
  } sfu_op_e;

  // bit positions inside the status byte
  localparam int unsigned BIT_C  = 0;
  localparam int unsigned BIT_DC = 1;
  localparam int unsigned BIT_Z  = 2;
  localparam int unsigned BIT_OV = 3;
  localparam int unsigned BIT_N  = 4;
  localparam int unsigned BIT_PD = 5;
  localparam int unsigned BIT_TO = 6;
  localparam int unsigned STAT_W = 8;
  localparam int unsigned WR_W   = 5;

  localparam logic [STAT_W-1:0] STAT_RESET = 8'h60;

  typedef struct packed {
    logic restore;   // bits 4:0 from shadow
    logic swWrite;   // bits 4:0 from software data
    logic aluLoad;   // flag update from ALU result
    logic updArith;  // C, DC, OV from adder
    logic updRot;    // C from shifted-out bit
    logic capture;   // shadow capture
    logic toSet;
    logic toClr;
    logic pdSet;
    logic pdClr;
  } sfu_strobe_t;

endpackage

// File: rtl/sfu_ctrl.sv
module sfu_ctrl
  import sfu_pkg::*;
(
  input  logic [2:0]  aluOp,
  input  logic        flagUpdEn,
  input  logic        swWrEn,
  input  logic        clrWdt,
  input  logic        sleepCmd,
  input  logic        wdtTimeout,
  input  logic        irqEnter,
  input  logic        irqReturn,
  output sfu_strobe_t strobes
);

  sfu_op_e opCode;

  always_comb begin
    opCode = sfu_op_e'(aluOp);

    strobes          = '0;
    strobes.restore  = irqReturn;
    strobes.swWrite  = swWrEn && !irqReturn;
    strobes.aluLoad  = flagUpdEn && !swWrEn && !irqReturn;
    strobes.capture  = irqEnter;

    unique case (opCode)
      OP_ADD, OP_SUB: strobes.updArith = 1'b1;
      OP_RRC, OP_RLC: strobes.updRot   = 1'b1;
      default: begin
        strobes.updArith = 1'b0;
        strobes.updRot   = 1'b0;
      end
    endcase

    // power-management flags
    strobes.toClr = wdtTimeout;
    strobes.toSet = (clrWdt || sleepCmd) && !wdtTimeout;
    strobes.pdClr = sleepCmd;
    strobes.pdSet = clrWdt && !sleepCmd;
  end

endmodule

// File: rtl/sfu_datapath.sv
module sfu_datapath
  import sfu_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] aluOpA,
  input  logic [DATA_W-1:0] aluOpB,
  input  logic [2:0]        aluOp,
  input  logic [STAT_W-1:0] swWrData,
  input  sfu_strobe_t       strobes,
  output logic [STAT_W-1:0] statusOut,
  output logic [STAT_W-1:0] shadowOut
);

  localparam int unsigned MSB = DATA_W - 1;

  logic [STAT_W-1:0] statReg;
  logic [STAT_W-1:0] shadowReg;

  logic [DATA_W-1:0] operandB;
  logic              carryIn;
  logic [DATA_W:0]   sumFull;
  logic [DATA_W-1:0] result;
  logic              carryOut;
  logic              nibCarry;
  logic              msbCarryIn;
  logic              rotCarry;
  logic              zeroFlag;
  logic              negFlag;
  logic [WR_W-1:0]   nextLow;

  // one adder serves add and subtract
  always_comb begin
    operandB = (aluOp == OP_SUB) ? ~aluOpB : aluOpB;
    carryIn  = (aluOp == OP_SUB);
    sumFull  = {1'b0, aluOpA} + {1'b0, operandB} + {{DATA_W{1'b0}}, carryIn};
    carryOut = sumFull[DATA_W];
    // carries recovered from sum bits and operand bits
    nibCarry   = sumFull[NIB_W] ^ aluOpA[NIB_W] ^ operandB[NIB_W];
    msbCarryIn = sumFull[MSB] ^ aluOpA[MSB] ^ operandB[MSB];
  end

  // result select for the zero and negative flags
  always_comb begin
    rotCarry = 1'b0;
    unique case (sfu_op_e'(aluOp))
      OP_ADD, OP_SUB: result = sumFull[DATA_W-1:0];
      OP_RRC: begin
        result   = {statReg[BIT_C], aluOpA[MSB:1]};
        rotCarry = aluOpA[0];
      end
      OP_RLC: begin
        result   = {aluOpA[MSB-1:0], statReg[BIT_C]};
        rotCarry = aluOpA[MSB];
      end
      OP_AND:  result = aluOpA & aluOpB;
      OP_IOR:  result = aluOpA | aluOpB;
      OP_XOR:  result = aluOpA ^ aluOpB;
      default: result = aluOpA;
    endcase
    zeroFlag = (result == '0);
    negFlag  = result[MSB];
  end

  // next value of the software-writable field
  always_comb begin
    nextLow = statReg[WR_W-1:0];
    if (strobes.restore) begin
      nextLow = shadowReg[WR_W-1:0];
    end else if (strobes.swWrite) begin
      nextLow = swWrData[WR_W-1:0];
    end else if (strobes.aluLoad) begin
      nextLow[BIT_Z] = zeroFlag;
      nextLow[BIT_N] = negFlag;
      if (strobes.updArith) begin
        nextLow[BIT_C]  = carryOut;
        nextLow[BIT_DC] = nibCarry;
        nextLow[BIT_OV] = msbCarryIn ^ carryOut;
      end else if (strobes.updRot) begin
        nextLow[BIT_C] = rotCarry;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statReg   <= STAT_RESET;
      shadowReg <= '0;
    end else begin
      statReg[WR_W-1:0] <= nextLow;
      statReg[STAT_W-1] <= 1'b0;
      if (strobes.toClr)      statReg[BIT_TO] <= 1'b0;
      else if (strobes.toSet) statReg[BIT_TO] <= 1'b1;
      if (strobes.pdClr)      statReg[BIT_PD] <= 1'b0;
      else if (strobes.pdSet) statReg[BIT_PD] <= 1'b1;
      if (strobes.capture)    shadowReg <= statReg;
    end
  end

  assign statusOut = statReg;
  assign shadowOut = shadowReg;

endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
  import sfu_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] aluOpA,
  input  logic [DATA_W-1:0] aluOpB,
  input  logic [2:0]        aluOp,
  input  logic              flagUpdEn,
  input  logic              swWrEn,
  input  logic [7:0]        swWrData,
  input  logic              clrWdt,
  input  logic              sleepCmd,
  input  logic              wdtTimeout,
  input  logic              irqEnter,
  input  logic              irqReturn,
  output logic [7:0]        statusOut,
  output logic [7:0]        shadowOut
);

  sfu_strobe_t strobes;

  sfu_ctrl ctrl_i (
    .aluOp      (aluOp),
    .flagUpdEn  (flagUpdEn),
    .swWrEn     (swWrEn),
    .clrWdt     (clrWdt),
    .sleepCmd   (sleepCmd),
    .wdtTimeout (wdtTimeout),
    .irqEnter   (irqEnter),
    .irqReturn  (irqReturn),
    .strobes    (strobes)
  );

  sfu_datapath #(
    .DATA_W (DATA_W),
    .NIB_W  (NIB_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .aluOpA    (aluOpA),
    .aluOpB    (aluOpB),
    .aluOp     (aluOp),
    .swWrData  (swWrData),
    .strobes   (strobes),
    .statusOut (statusOut),
    .shadowOut (shadowOut)
  );

endmodule

// File: rtl/sfu_checker.sv
module sfu_checker (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] aluOp,
  input logic       flagUpdEn,
  input logic       swWrEn,
  input logic       clrWdt,
  input logic       sleepCmd,
  input logic       wdtTimeout,
  input logic       irqEnter,
  input logic       irqReturn,
  input logic [7:0] statusOut,
  input logic [7:0] shadowOut
);

  assert_msb_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[7] == 1'b0);

  assert_timeout_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    wdtTimeout |=> !statusOut[6]);

  assert_sleep_R9: assert property (@(posedge clk) disable iff (!rstN)
    (sleepCmd && !wdtTimeout) |=> (statusOut[6] && !statusOut[5]));

  assert_clrwdt_R9: assert property (@(posedge clk) disable iff (!rstN)
    (clrWdt && !sleepCmd && !wdtTimeout) |=> (statusOut[6] && statusOut[5]));

  assert_pm_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!clrWdt && !sleepCmd && !wdtTimeout) |=> $stable(statusOut[6:5]));

  assert_capture_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqEnter |=> (shadowOut == $past(statusOut)));

  assert_restore_R11: assert property (@(posedge clk) disable iff (!rstN)
    irqReturn |=> (statusOut[4:0] == $past(shadowOut[4:0])));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!flagUpdEn && !swWrEn && !irqReturn) |=> $stable(statusOut[4:0]));

  assert_logic_keeps_R6: assert property (@(posedge clk) disable iff (!rstN)
    (flagUpdEn && aluOp[2] && !swWrEn && !irqReturn)
      |=> ($stable(statusOut[3]) && $stable(statusOut[1:0])));

endmodule

bind status_flag_unit sfu_checker chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .aluOp      (aluOp),
  .flagUpdEn  (flagUpdEn),
  .swWrEn     (swWrEn),
  .clrWdt     (clrWdt),
  .sleepCmd   (sleepCmd),
  .wdtTimeout (wdtTimeout),
  .irqEnter   (irqEnter),
  .irqReturn  (irqReturn),
  .statusOut  (statusOut),
  .shadowOut  (shadowOut)
);

// File: tb/status_flag_unit_tb.sv
module status_flag_unit_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] aluOpA = '0;
  logic [7:0] aluOpB = '0;
  logic [2:0] aluOp = '0;
  logic       flagUpdEn = 1'b0;
  logic       swWrEn = 1'b0;
  logic [7:0] swWrData = '0;
  logic       clrWdt = 1'b0;
  logic       sleepCmd = 1'b0;
  logic       wdtTimeout = 1'b0;
  logic       irqEnter = 1'b0;
  logic       irqReturn = 1'b0;
  logic [7:0] statusOut;
  logic [7:0] shadowOut;

  int totalChecks = 0;
  int badChecks = 0;

  always #5 clk = ~clk;

  status_flag_unit dut_i (
    .clk(clk), .rstN(rstN), .aluOpA(aluOpA), .aluOpB(aluOpB), .aluOp(aluOp),
    .flagUpdEn(flagUpdEn), .swWrEn(swWrEn), .swWrData(swWrData),
    .clrWdt(clrWdt), .sleepCmd(sleepCmd), .wdtTimeout(wdtTimeout),
    .irqEnter(irqEnter), .irqReturn(irqReturn),
    .statusOut(statusOut), .shadowOut(shadowOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    totalChecks++;
    if (act !== exp) begin
      badChecks++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one rising edge, then sample point on the falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clearStrobes();
    flagUpdEn = 0; swWrEn = 0; clrWdt = 0; sleepCmd = 0;
    wdtTimeout = 0; irqEnter = 0; irqReturn = 0;
  endtask

  task automatic doReset();
    clearStrobes();
    rstN = 0;
    tick();
    rstN = 1;
    tick();
  endtask

  task automatic aluStep(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
    aluOp = op; aluOpA = a; aluOpB = b; flagUpdEn = 1;
    tick();
    flagUpdEn = 0;
  endtask

  task automatic swWrite(input logic [7:0] d);
    swWrData = d; swWrEn = 1;
    tick();
    swWrEn = 0;
  endtask

  // expected low five bits for add/sub, from integer arithmetic
  function automatic logic [4:0] arithModel(input bit isSub, input logic [7:0] a, input logic [7:0] b);
    int ua, ub, un, sa, sb, sr, r;
    logic c, dc, z, n, ov;
    ua = a; ub = b;
    sa = $signed(a); sb = $signed(b);
    if (isSub) begin
      r  = (ua - ub) & 255;
      c  = (ua >= ub);
      dc = ((ua & 15) >= (ub & 15));
      sr = sa - sb;
    end else begin
      un = ua + ub;
      r  = un & 255;
      c  = (un > 255);
      dc = (((ua & 15) + (ub & 15)) > 15);
      sr = sa + sb;
    end
    ov = (sr > 127) || (sr < -128);
    z  = (r == 0);
    n  = (r >= 128);
    return {n, ov, z, dc, c};
  endfunction

  task automatic testReset();
    doReset();
    check("R1 status", statusOut, 8'h60);
    check("R1 shadow", shadowOut, 8'h00);
  endtask

  task automatic testAdd();
    doReset();
    aluStep(3'd0, 8'h0F, 8'h01); check("R2 add nibble carry", statusOut, 8'h62);
    aluStep(3'd0, 8'h80, 8'h80); check("R2 R4 add carry zero ov", statusOut, 8'h6D);
    aluStep(3'd0, 8'h7F, 8'h01); check("R4 add ov neg", statusOut, 8'h7A);
    for (int i = 0; i < 24; i++) begin
      logic [7:0] a, b;
      a = 8'(i * 37 + 5); b = 8'(i * 91 + 200);
      aluStep(3'd0, a, b);
      check("R2 R4 add sweep", statusOut, {3'b011, arithModel(0, a, b)});
    end
  endtask

  task automatic testSub();
    doReset();
    aluStep(3'd1, 8'h05, 8'h03); check("R3 sub no borrow", statusOut, 8'h63);
    aluStep(3'd1, 8'h03, 8'h05); check("R3 sub borrow", statusOut, 8'h70);
    aluStep(3'd1, 8'h80, 8'h01); check("R4 sub ov", statusOut, 8'h69);
    aluStep(3'd1, 8'h10, 8'h10); check("R3 sub zero", statusOut, 8'h67);
    for (int i = 0; i < 24; i++) begin
      logic [7:0] a, b;
      a = 8'(i * 53 + 17); b = 8'(i * 29 + 3);
      aluStep(3'd1, a, b);
      check("R3 R4 sub sweep", statusOut, {3'b011, arithModel(1, a, b)});
    end
  endtask

  task automatic testRotate();
    doReset();
    swWrite(8'h01);
    aluStep(3'd2, 8'h02, 8'h00); check("R5 rrc carry in", statusOut, 8'h70);
    aluStep(3'd3, 8'h80, 8'h00); check("R5 rlc carry out", statusOut, 8'h65);
    swWrite(8'h0A);
    aluStep(3'd2, 8'h01, 8'h00); check("R5 rrc keeps dc ov", statusOut, 8'h6F);
    aluStep(3'd3, 8'h40, 8'h00); check("R5 rlc carry in neg", statusOut, 8'h7A);
  endtask

  task automatic testLogic();
    doReset();
    swWrite(8'h0B);
    aluStep(3'd4, 8'hF0, 8'h0F); check("R6 and zero", statusOut, 8'h6F);
    aluStep(3'd6, 8'h80, 8'h00); check("R6 xor neg", statusOut, 8'h7B);
    aluStep(3'd5, 8'h01, 8'h02); check("R6 ior", statusOut, 8'h6B);
    aluStep(3'd7, 8'h00, 8'hFF); check("R6 pass zero", statusOut, 8'h6F);
  endtask

  task automatic testNoUpdate();
    doReset();
    aluOp = 3'd0; aluOpA = 8'h80; aluOpB = 8'h80; flagUpdEn = 0;
    tick();
    check("R7 idle hold", statusOut, 8'h60);
  endtask

  task automatic testSwWrite();
    doReset();
    swWrite(8'hFF); check("R8 write high bits ignored", statusOut, 8'h7F);
    sleepCmd = 1; tick(); sleepCmd = 0;
    swWrite(8'hE0); check("R8 write keeps pd clear", statusOut, 8'h40);
    // software write beats flag update
    aluOp = 3'd0; aluOpA = 8'h80; aluOpB = 8'h80; flagUpdEn = 1;
    swWrData = 8'h00; swWrEn = 1;
    tick(); clearStrobes();
    check("R12 write over update", statusOut, 8'h40);
  endtask

  task automatic testPower();
    doReset();
    wdtTimeout = 1; tick(); clearStrobes(); check("R9 timeout", statusOut, 8'h20);
    clrWdt = 1; tick(); clearStrobes(); check("R9 clrwdt", statusOut, 8'h60);
    sleepCmd = 1; tick(); clearStrobes(); check("R9 sleep", statusOut, 8'h40);
    clrWdt = 1; tick(); clearStrobes(); check("R9 clrwdt after sleep", statusOut, 8'h60);
    wdtTimeout = 1; clrWdt = 1; tick(); clearStrobes(); check("R9 timeout wins", statusOut, 8'h20);
    sleepCmd = 1; clrWdt = 1; tick(); clearStrobes(); check("R9 sleep wins pd", statusOut, 8'h40);
  endtask

  task automatic testShadow();
    doReset();
    swWrite(8'h15);
    irqEnter = 1; swWrData = 8'h0A; swWrEn = 1;
    tick(); clearStrobes();
    check("R10 capture pre-edge value", shadowOut, 8'h75);
    check("R8 write alongside capture", statusOut, 8'h6A);
    sleepCmd = 1; tick(); clearStrobes();
    irqReturn = 1; tick(); clearStrobes();
    check("R11 restore keeps pd", statusOut, 8'h55);
    swWrite(8'h00);
    irqReturn = 1; swWrEn = 1; swWrData = 8'h1F;
    aluOp = 3'd0; aluOpA = 8'h80; aluOpB = 8'h80; flagUpdEn = 1;
    tick(); clearStrobes();
    check("R12 restore priority", statusOut, 8'h55);
    wdtTimeout = 1; irqReturn = 1; tick(); clearStrobes();
    check("R11 timeout not restored", statusOut, 8'h15);
  endtask

  initial begin
    testReset();
    testAdd();
    testSub();
    testRotate();
    testLogic();
    testNoUpdate();
    testSwWrite();
    testPower();
    testShadow();
    $display("test done: total=%0d bad=%0d", totalChecks, badChecks);
    $finish;
  end

  initial begin
    #1000000;
    totalChecks++;
    badChecks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", totalChecks, badChecks);
    $finish;
  end

endmodule